// File: doc/BRIEF.md
# Split Completion Response Handler

This block is the complete-split stage of a high-speed USB host scheduler. It handles periodic interrupt transfers to full- or low-speed devices that sit behind a hub transaction translator. For every scheduling opportunity the scheduler presents one queue-head snapshot together with the outcome of the complete-split transaction on that slot. The block first decides whether a complete-split may be issued at all. If it may, the block applies the response rules and returns the updated queue-head fields. It also returns a next-state code: stay, retry now, go back to start-split, advance, or halt.

The snapshot carries the scheduled completion mask, the progress mask, the frame tag, the 2-bit error credit, an 8-bit status byte, the transfer offset, the remaining byte count, the data toggle and the accumulated IN byte count. The outcome carries a response code, the received byte count, the direction and a flag that says whether time remains in the micro-frame. The result is registered and appears one clock after the request.

Top module: `csplit_resp_handler`

## Requirements
- R1: A complete-split is issued (`res_issued`=1) only when four conditions all hold. The completion mask has the current micro-frame bit (bit `uf_idx`) set. `qh_tag` equals `cur_tag`. `prev_ok`=1. `test_d`=0. Otherwise every queue-head field passes through unchanged and the next state is stay.
- R2: On issue, the progress mask becomes the old progress mask ORed with the current micro-frame bit, and the frame tag becomes `exp_tag`.
- R3: The split is the last one when the completion mask XOR the updated progress mask is zero.
- R4: Response code 0 (NYET) on a split that is not the last changes only the progress mask and the frame tag. The error credit is unchanged and the next state is stay (code 0).
- R5: NYET on the last split decrements the error credit and sets the transaction-error status bit (bit `XACT_POS`, default 3). The transfer fields are not advanced and the next state is start-split (code 2).
- R6: Response code 1 (transaction error) decrements the error credit and sets the transaction-error bit. If the credit is still non-zero and `time_left`=1, the next state is retry (code 1).
- R7: A transaction error with `time_left`=0 halts the queue for an IN endpoint (`dir_in`=1). For an OUT endpoint whose credit is still non-zero, it returns to start-split.
- R8: A decrement that leaves the credit at zero always halts (code 4) and sets the halted status bit (bit `HALT_POS`, default 6). A decrement from zero saturates at zero and halts.
- R9: Response code 2 (ACK) on an OUT endpoint works with the smaller of `max_pkt` and the remaining bytes. It adds that amount to the offset (wrapping at the offset width), subtracts it from the remaining bytes and toggles the data toggle. It reloads the credit to all ones (3) and moves to advance (code 3).
- R10: Response code 3 (MDATA) on an IN endpoint adds `rx_bytes` to the accumulated IN count (wrapping at its width). The credit is unchanged and the next state is stay.
- R11: ACK on an IN endpoint and MDATA on an OUT endpoint are handled exactly as a transaction error.
- R12: The result appears one clock after `cs_valid` is high, with `res_valid`=1. A clock without `cs_valid` gives `res_valid`=0. Reset clears `res_valid` and all result fields to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_valid | input | 1 | Request present this cycle |
| uf_idx | input | IDX_W | Current micro-frame number |
| cur_tag | input | TAG_W | Current frame number for the tag match |
| exp_tag | input | TAG_W | Expected frame number written into the tag on issue |
| prev_ok | input | 1 | Previous complete-split finished properly |
| test_d | input | 1 | Blocking condition; must be low to issue |
| qh_cmask | input | MASK_W | Scheduled completion mask |
| qh_pmask | input | MASK_W | Progress mask |
| qh_tag | input | TAG_W | Frame tag |
| qh_cerr | input | CERR_W | Error credit |
| qh_status | input | 8 | Status byte |
| qh_offset | input | OFS_W | Transfer offset |
| qh_bytes | input | BYTES_W | Remaining bytes to transfer |
| qh_toggle | input | 1 | Data toggle |
| qh_sbytes | input | SB_W | Accumulated IN split bytes |
| max_pkt | input | MPL_W | Maximum packet length |
| rsp | input | 2 | Response: 0 NYET, 1 error, 2 ACK, 3 MDATA |
| rx_bytes | input | SB_W | Bytes received with MDATA |
| dir_in | input | 1 | 1 for IN endpoint, 0 for OUT |
| time_left | input | 1 | Time remains in the micro-frame |
| res_valid | output | 1 | Result valid |
| res_issued | output | 1 | Complete-split was issued |
| res_next | output | 3 | 0 stay, 1 retry, 2 start-split, 3 advance, 4 halt |
| res_pmask | output | MASK_W | Updated progress mask |
| res_tag | output | TAG_W | Updated frame tag |
| res_cerr | output | CERR_W | Updated error credit |
| res_status | output | 8 | Updated status byte |
| res_offset | output | OFS_W | Updated offset |
| res_bytes | output | BYTES_W | Updated remaining bytes |
| res_toggle | output | 1 | Updated data toggle |
| res_sbytes | output | SB_W | Updated accumulated IN bytes |

## Verification
The bench builds the block with an 8-bit offset, a 10-bit byte count, a 10-bit maximum packet length and a 5-bit IN byte accumulator. The narrow offset and accumulator make wrap-around on ACK and MDATA occur often under random stimulus. The equal widths of byte count and packet length let both sides of the minimum be chosen. The 2-bit credit makes every path that decrements to zero, including the saturating decrement from zero, reachable within a few random draws.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
   typedef enum logic [1:0] {
      RSP_NYET  = 2'd0,
      RSP_XERR  = 2'd1,
      RSP_ACK   = 2'd2,
      RSP_MDATA = 2'd3
   } rsp_e;

   typedef enum logic [2:0] {
      NX_STAY    = 3'd0,
      NX_RETRY   = 3'd1,
      NX_START   = 3'd2,
      NX_ADVANCE = 3'd3,
      NX_HALT    = 3'd4
   } nxt_e;

   localparam int unsigned STAT_W = 8;
endpackage

// File: rtl/csplit_issue_gate.sv
module csplit_issue_gate #(
   parameter int unsigned MASK_W = 8,
   parameter int unsigned TAG_W  = 5,
   localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
   input  logic [IDX_W-1:0]  uf_idx,
   input  logic [MASK_W-1:0] cmask,
   input  logic [MASK_W-1:0] pmask,
   input  logic [TAG_W-1:0]  qh_tag,
   input  logic [TAG_W-1:0]  cur_tag,
   input  logic              prev_ok,
   input  logic              test_d,
   output logic              issue,
   output logic [MASK_W-1:0] uf_bit,
   output logic [MASK_W-1:0] pmask_new,
   output logic              last
);
   if (MASK_W < 2 || MASK_W > 32) begin : g_bad_mask
      $error("csplit_issue_gate: MASK_W must be in 2..32");
   end

   for (genvar i = 0; i < MASK_W; i++) begin : g_ufdec
      assign uf_bit[i] = (uf_idx == IDX_W'(i));
   end

   logic sched_hit;
   assign sched_hit = |(cmask & uf_bit);
   assign issue     = sched_hit && (qh_tag == cur_tag) && prev_ok && !test_d;
   assign pmask_new = issue ? (pmask | uf_bit) : pmask;
   assign last      = ((cmask ^ pmask_new) == '0);
endmodule

// File: rtl/csplit_resp_rules.sv
module csplit_resp_rules
   import csplit_pkg::*;
#(
   parameter int unsigned CERR_W   = 2,
   parameter int unsigned XACT_POS = 3,
   parameter int unsigned HALT_POS = 6
) (
   input  logic              issue,
   input  logic              last,
   input  logic [1:0]        rsp,
   input  logic              dir_in,
   input  logic              time_left,
   input  logic [CERR_W-1:0] cerr,
   input  logic [STAT_W-1:0] status,
   output logic [CERR_W-1:0] cerr_n,
   output logic [STAT_W-1:0] status_n,
   output logic [2:0]        nxt,
   output logic              do_ack,
   output logic              do_mdata
);
   if (XACT_POS >= STAT_W || HALT_POS >= STAT_W || XACT_POS == HALT_POS) begin : g_bad_pos
      $error("csplit_resp_rules: status bit positions invalid");
   end
   if (CERR_W < 1 || CERR_W > 8) begin : g_bad_cerr
      $error("csplit_resp_rules: CERR_W must be in 1..8");
   end

   rsp_e        kind;
   logic [CERR_W-1:0] cerr_dec;
   logic        halt;

   assign cerr_dec = (cerr == '0) ? '0 : cerr - 1'b1;

   always_comb begin
      kind = rsp_e'(rsp);
      if ((kind == RSP_ACK && dir_in) || (kind == RSP_MDATA && !dir_in)) begin
         kind = RSP_XERR;
      end
   end

   always_comb begin
      cerr_n   = cerr;
      status_n = status;
      nxt      = NX_STAY;
      do_ack   = 1'b0;
      do_mdata = 1'b0;
      halt     = 1'b0;
      if (issue) begin
         unique case (kind)
            RSP_NYET: begin
               if (last) begin
                  cerr_n             = cerr_dec;
                  status_n[XACT_POS] = 1'b1;
                  if (cerr_dec == '0) halt = 1'b1;
                  else                nxt  = NX_START;
               end
            end
            RSP_XERR: begin
               cerr_n             = cerr_dec;
               status_n[XACT_POS] = 1'b1;
               if (cerr_dec == '0)  halt = 1'b1;
               else if (time_left)  nxt  = NX_RETRY;
               else if (dir_in)     halt = 1'b1;
               else                 nxt  = NX_START;
            end
            RSP_ACK: begin
               do_ack = 1'b1;
               cerr_n = '1;
               nxt    = NX_ADVANCE;
            end
            RSP_MDATA: begin
               do_mdata = 1'b1;
            end
            default: ;
         endcase
         if (halt) begin
            status_n[HALT_POS] = 1'b1;
            nxt                = NX_HALT;
         end
      end
   end
endmodule

// File: rtl/csplit_xfer_adv.sv
module csplit_xfer_adv #(
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned BYTES_W = 15,
   parameter int unsigned MPL_W   = 11,
   parameter int unsigned SB_W    = 7
) (
   input  logic               do_ack,
   input  logic               do_mdata,
   input  logic [OFS_W-1:0]   offset,
   input  logic [BYTES_W-1:0] bytes,
   input  logic [MPL_W-1:0]   max_pkt,
   input  logic               toggle,
   input  logic [SB_W-1:0]    sbytes,
   input  logic [SB_W-1:0]    rx_bytes,
   output logic [OFS_W-1:0]   offset_n,
   output logic [BYTES_W-1:0] bytes_n,
   output logic               toggle_n,
   output logic [SB_W-1:0]    sbytes_n
);
   if (MPL_W > BYTES_W) begin : g_bad_mpl
      $error("csplit_xfer_adv: MPL_W must not exceed BYTES_W");
   end

   logic [BYTES_W-1:0] mpl_ext;
   logic [BYTES_W-1:0] amt;
   logic [OFS_W-1:0]   amt_o;

   assign mpl_ext = BYTES_W'(max_pkt);
   assign amt     = (mpl_ext < bytes) ? mpl_ext : bytes;

   if (OFS_W <= BYTES_W) begin : g_amt_slice
      assign amt_o = amt[OFS_W-1:0];
   end else begin : g_amt_ext
      assign amt_o = OFS_W'(amt);
   end

   assign offset_n = do_ack   ? offset + amt_o   : offset;
   assign bytes_n  = do_ack   ? bytes - amt      : bytes;
   assign toggle_n = do_ack   ? ~toggle          : toggle;
   assign sbytes_n = do_mdata ? sbytes + rx_bytes : sbytes;
endmodule

// File: rtl/csplit_resp_handler.sv
module csplit_resp_handler
   import csplit_pkg::*;
#(
   parameter int unsigned MASK_W   = 8,
   parameter int unsigned TAG_W    = 5,
   parameter int unsigned CERR_W   = 2,
   parameter int unsigned OFS_W    = 12,
   parameter int unsigned BYTES_W  = 15,
   parameter int unsigned MPL_W    = 11,
   parameter int unsigned SB_W     = 7,
   parameter int unsigned XACT_POS = 3,
   parameter int unsigned HALT_POS = 6,
   localparam int unsigned IDX_W   = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_valid,
   input  logic [IDX_W-1:0]   uf_idx,
   input  logic [TAG_W-1:0]   cur_tag,
   input  logic [TAG_W-1:0]   exp_tag,
   input  logic               prev_ok,
   input  logic               test_d,
   input  logic [MASK_W-1:0]  qh_cmask,
   input  logic [MASK_W-1:0]  qh_pmask,
   input  logic [TAG_W-1:0]   qh_tag,
   input  logic [CERR_W-1:0]  qh_cerr,
   input  logic [7:0]         qh_status,
   input  logic [OFS_W-1:0]   qh_offset,
   input  logic [BYTES_W-1:0] qh_bytes,
   input  logic               qh_toggle,
   input  logic [SB_W-1:0]    qh_sbytes,
   input  logic [MPL_W-1:0]   max_pkt,
   input  logic [1:0]         rsp,
   input  logic [SB_W-1:0]    rx_bytes,
   input  logic               dir_in,
   input  logic               time_left,
   output logic               res_valid,
   output logic               res_issued,
   output logic [2:0]         res_next,
   output logic [MASK_W-1:0]  res_pmask,
   output logic [TAG_W-1:0]   res_tag,
   output logic [CERR_W-1:0]  res_cerr,
   output logic [7:0]         res_status,
   output logic [OFS_W-1:0]   res_offset,
   output logic [BYTES_W-1:0] res_bytes,
   output logic               res_toggle,
   output logic [SB_W-1:0]    res_sbytes
);
   if (TAG_W < 1 || OFS_W < 1 || SB_W < 1) begin : g_bad_w
      $error("csplit_resp_handler: field widths must be positive");
   end

   logic               issue, last, do_ack, do_mdata;
   logic [MASK_W-1:0]  uf_bit, pmask_n;
   logic [CERR_W-1:0]  cerr_n;
   logic [STAT_W-1:0]  status_n;
   logic [2:0]         nxt;
   logic [OFS_W-1:0]   offset_n;
   logic [BYTES_W-1:0] bytes_n;
   logic               toggle_n;
   logic [SB_W-1:0]    sbytes_n;

   csplit_issue_gate #(.MASK_W(MASK_W), .TAG_W(TAG_W)) u_gate (
      .uf_idx(uf_idx), .cmask(qh_cmask), .pmask(qh_pmask), .qh_tag(qh_tag),
      .cur_tag(cur_tag), .prev_ok(prev_ok), .test_d(test_d), .issue(issue),
      .uf_bit(uf_bit), .pmask_new(pmask_n), .last(last)
   );

   csplit_resp_rules #(.CERR_W(CERR_W), .XACT_POS(XACT_POS), .HALT_POS(HALT_POS)) u_rules (
      .issue(issue), .last(last), .rsp(rsp), .dir_in(dir_in), .time_left(time_left),
      .cerr(qh_cerr), .status(qh_status), .cerr_n(cerr_n), .status_n(status_n),
      .nxt(nxt), .do_ack(do_ack), .do_mdata(do_mdata)
   );

   csplit_xfer_adv #(.OFS_W(OFS_W), .BYTES_W(BYTES_W), .MPL_W(MPL_W), .SB_W(SB_W)) u_adv (
      .do_ack(do_ack), .do_mdata(do_mdata), .offset(qh_offset), .bytes(qh_bytes),
      .max_pkt(max_pkt), .toggle(qh_toggle), .sbytes(qh_sbytes), .rx_bytes(rx_bytes),
      .offset_n(offset_n), .bytes_n(bytes_n), .toggle_n(toggle_n), .sbytes_n(sbytes_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_issued <= 1'b0;
         res_next   <= '0;
         res_pmask  <= '0;
         res_tag    <= '0;
         res_cerr   <= '0;
         res_status <= '0;
         res_offset <= '0;
         res_bytes  <= '0;
         res_toggle <= 1'b0;
         res_sbytes <= '0;
      end else begin
         res_valid <= cs_valid;
         if (cs_valid) begin
            res_issued <= issue;
            res_next   <= nxt;
            res_pmask  <= pmask_n;
            res_tag    <= issue ? exp_tag : qh_tag;
            res_cerr   <= cerr_n;
            res_status <= status_n;
            res_offset <= offset_n;
            res_bytes  <= bytes_n;
            res_toggle <= toggle_n;
            res_sbytes <= sbytes_n;
         end
      end
   end

   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cs_valid |=> res_valid);
   a_r12_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_valid |=> !res_valid);
   a_r1_no_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_valid && !issue) |=> (res_next == NX_STAY && !res_issued
                                && res_cerr == $past(qh_cerr) && res_pmask == $past(qh_pmask)));
   a_r2_bit_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_valid && issue) |=> ((res_pmask & $past(uf_bit)) == $past(uf_bit)
                               && res_tag == $past(exp_tag)));
   a_r4_nyet_keeps_credit: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_valid && issue && rsp == RSP_NYET && !last) |=>
         (res_cerr == $past(qh_cerr) && res_next == NX_STAY && res_offset == $past(qh_offset)));
   a_r8_halt_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_next == NX_HALT) |-> res_status[HALT_POS]);
   a_r8_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_next == NX_HALT) |-> (res_cerr == '0 || $past(dir_in)));
   a_r6_retry_credit: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_next == NX_RETRY) |-> (res_cerr != '0 && res_status[XACT_POS]));
   a_r9_ack_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_next == NX_ADVANCE) |-> (res_cerr == '1 && res_toggle != $past(qh_toggle)));
endmodule

// File: tb/csplit_resp_handler_bench.sv
module csplit_resp_handler_bench;
   localparam int MASK_W = 8, TAG_W = 5, CERR_W = 2, OFS_W = 8, BYTES_W = 10;
   localparam int MPL_W = 10, SB_W = 5, XACT_POS = 3, HALT_POS = 6;

   typedef struct {
      int uf, cur, etag, prev, td, cmask, pmask, tag, cerr, status;
      int offset, bytes, toggle, sbytes, mpl, rsp, rx, dir, tleft;
   } stim_t;

   typedef struct {
      int issued, nxt, pmask, tag, cerr, status, offset, bytes, toggle, sbytes;
      string req;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0, cs_valid = 1'b0;
   logic [2:0] uf_idx = '0;
   logic [TAG_W-1:0] cur_tag = '0, exp_tag = '0, qh_tag = '0;
   logic prev_ok = 1'b0, test_d = 1'b0, qh_toggle = 1'b0, dir_in = 1'b0, time_left = 1'b0;
   logic [MASK_W-1:0] qh_cmask = '0, qh_pmask = '0;
   logic [CERR_W-1:0] qh_cerr = '0;
   logic [7:0] qh_status = '0;
   logic [OFS_W-1:0] qh_offset = '0;
   logic [BYTES_W-1:0] qh_bytes = '0;
   logic [SB_W-1:0] qh_sbytes = '0, rx_bytes = '0;
   logic [MPL_W-1:0] max_pkt = '0;
   logic [1:0] rsp = '0;
   logic res_valid, res_issued, res_toggle;
   logic [2:0] res_next;
   logic [MASK_W-1:0] res_pmask;
   logic [TAG_W-1:0] res_tag;
   logic [CERR_W-1:0] res_cerr;
   logic [7:0] res_status;
   logic [OFS_W-1:0] res_offset;
   logic [BYTES_W-1:0] res_bytes;
   logic [SB_W-1:0] res_sbytes;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   csplit_resp_handler #(.MASK_W(MASK_W), .TAG_W(TAG_W), .CERR_W(CERR_W), .OFS_W(OFS_W),
      .BYTES_W(BYTES_W), .MPL_W(MPL_W), .SB_W(SB_W), .XACT_POS(XACT_POS), .HALT_POS(HALT_POS))
   u_csplit_resp_handler (
      .clk(clk), .rst_n(rst_n), .cs_valid(cs_valid), .uf_idx(uf_idx), .cur_tag(cur_tag),
      .exp_tag(exp_tag), .prev_ok(prev_ok), .test_d(test_d), .qh_cmask(qh_cmask),
      .qh_pmask(qh_pmask), .qh_tag(qh_tag), .qh_cerr(qh_cerr), .qh_status(qh_status),
      .qh_offset(qh_offset), .qh_bytes(qh_bytes), .qh_toggle(qh_toggle), .qh_sbytes(qh_sbytes),
      .max_pkt(max_pkt), .rsp(rsp), .rx_bytes(rx_bytes), .dir_in(dir_in), .time_left(time_left),
      .res_valid(res_valid), .res_issued(res_issued), .res_next(res_next), .res_pmask(res_pmask),
      .res_tag(res_tag), .res_cerr(res_cerr), .res_status(res_status), .res_offset(res_offset),
      .res_bytes(res_bytes), .res_toggle(res_toggle), .res_sbytes(res_sbytes)
   );

   function automatic exp_t model(stim_t s);
      exp_t e;
      int ufb, kind, dec, amt, halt;
      ufb = 1 << s.uf;
      e = '{0, 0, s.pmask, s.tag, s.cerr, s.status, s.offset, s.bytes, s.toggle, s.sbytes, "R1"};
      if ((s.cmask & ufb) == 0 || s.tag != s.cur || s.prev == 0 || s.td != 0) return e;
      e.issued = 1;
      e.pmask  = s.pmask | ufb;
      e.tag    = s.etag;
      e.req    = "R2";
      kind = s.rsp;
      if ((kind == 2 && s.dir == 1) || (kind == 3 && s.dir == 0)) begin
         kind = 1;
         e.req = "R11";
      end
      dec = (s.cerr == 0) ? 0 : s.cerr - 1;
      halt = 0;
      if (kind == 0) begin
         if ((s.cmask ^ e.pmask) == 0) begin
            e.req = "R5"; e.cerr = dec; e.status |= (1 << XACT_POS);
            if (dec == 0) halt = 1; else e.nxt = 2;
         end else e.req = "R4";
      end else if (kind == 1) begin
         e.cerr = dec; e.status |= (1 << XACT_POS);
         if (e.req != "R11") e.req = s.tleft ? "R6" : "R7";
         if (dec == 0) halt = 1;
         else if (s.tleft) e.nxt = 1;
         else if (s.dir) halt = 1;
         else e.nxt = 2;
      end else if (kind == 2) begin
         e.req = "R9";
         amt = (s.mpl < s.bytes) ? s.mpl : s.bytes;
         e.offset = (s.offset + amt) % (1 << OFS_W);
         e.bytes  = s.bytes - amt;
         e.toggle = s.toggle ^ 1;
         e.cerr   = (1 << CERR_W) - 1;
         e.nxt    = 3;
      end else begin
         e.req = "R10";
         e.sbytes = (s.sbytes + s.rx) % (1 << SB_W);
      end
      if (halt) begin
         e.status |= (1 << HALT_POS);
         e.nxt = 4;
         if (e.req != "R11") e.req = "R8";
      end
      return e;
   endfunction

   task automatic cmp(string req, string fld, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, fld, act, exp);
      end
   endtask

   task automatic run(stim_t s);
      exp_t e;
      e = model(s);
      cs_valid = 1'b1;
      uf_idx = 3'(s.uf); cur_tag = TAG_W'(s.cur); exp_tag = TAG_W'(s.etag);
      prev_ok = s.prev[0]; test_d = s.td[0]; qh_cmask = MASK_W'(s.cmask);
      qh_pmask = MASK_W'(s.pmask); qh_tag = TAG_W'(s.tag); qh_cerr = CERR_W'(s.cerr);
      qh_status = 8'(s.status); qh_offset = OFS_W'(s.offset); qh_bytes = BYTES_W'(s.bytes);
      qh_toggle = s.toggle[0]; qh_sbytes = SB_W'(s.sbytes); max_pkt = MPL_W'(s.mpl);
      rsp = 2'(s.rsp); rx_bytes = SB_W'(s.rx); dir_in = s.dir[0]; time_left = s.tleft[0];
      @(negedge clk);
      cmp("R12", "valid", int'(res_valid), 1);
      cmp(e.req, "issued", int'(res_issued), e.issued);
      cmp(e.req, "next", int'(res_next), e.nxt);
      cmp(e.req, "pmask", int'(res_pmask), e.pmask);
      cmp(e.req, "tag", int'(res_tag), e.tag);
      cmp(e.req, "cerr", int'(res_cerr), e.cerr);
      cmp(e.req, "status", int'(res_status), e.status);
      cmp(e.req, "offset", int'(res_offset), e.offset);
      cmp(e.req, "bytes", int'(res_bytes), e.bytes);
      cmp(e.req, "toggle", int'(res_toggle), e.toggle);
      cmp(e.req, "sbytes", int'(res_sbytes), e.sbytes);
   endtask

   function automatic stim_t base();
      stim_t s;
      s = '{uf:2, cur:5, etag:9, prev:1, td:0, cmask:'h1C, pmask:0, tag:5, cerr:3,
            status:'h01, offset:10, bytes:100, toggle:0, sbytes:4, mpl:64, rsp:0,
            rx:7, dir:1, tleft:1};
      return s;
   endfunction

   function automatic stim_t rnd();
      stim_t s;
      int ufb;
      s.uf = $urandom_range(0, 7); ufb = 1 << s.uf;
      s.cmask = $urandom_range(0, 255);
      if ($urandom_range(0, 9) < 8) s.cmask |= ufb;
      s.pmask = ($urandom_range(0, 1) == 1) ? (s.cmask & ~ufb) : ($urandom_range(0, 255) & ~ufb);
      s.tag = $urandom_range(0, 31);
      s.cur = ($urandom_range(0, 9) < 9) ? s.tag : $urandom_range(0, 31);
      s.etag = $urandom_range(0, 31);
      s.prev = ($urandom_range(0, 9) != 0) ? 1 : 0;
      s.td = ($urandom_range(0, 9) == 0) ? 1 : 0;
      s.cerr = $urandom_range(0, 3); s.status = $urandom_range(0, 255);
      s.offset = $urandom_range(0, 255); s.bytes = $urandom_range(0, 1023);
      s.toggle = $urandom_range(0, 1); s.sbytes = $urandom_range(0, 31);
      s.mpl = $urandom_range(0, 1023); s.rsp = $urandom_range(0, 3);
      s.rx = $urandom_range(0, 31); s.dir = $urandom_range(0, 1); s.tleft = $urandom_range(0, 1);
      return s;
   endfunction

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_bad++;
            $display("FAIL R12 watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      stim_t s;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R12: reset state
      cmp("R12", "valid", int'(res_valid), 0);
      cmp("R12", "next", int'(res_next), 0);
      cmp("R12", "cerr", int'(res_cerr), 0);
      cmp("R12", "offset", int'(res_offset), 0);
      rst_n = 1'b1;
      // R1: each blocking condition alone
      s = base(); s.td = 1; run(s);
      s = base(); s.prev = 0; run(s);
      s = base(); s.cur = 6; run(s);
      s = base(); s.uf = 0; run(s);
      // R4: NYET not last
      s = base(); run(s);
      // R5 / R3: NYET on last split
      s = base(); s.pmask = 'h18; run(s);
      // R8: NYET last with credit 1
      s = base(); s.pmask = 'h18; s.cerr = 1; run(s);
      // R6: error with time left
      s = base(); s.rsp = 1; run(s);
      // R7: error, no time, OUT then IN
      s = base(); s.rsp = 1; s.tleft = 0; s.dir = 0; s.cerr = 2; run(s);
      s = base(); s.rsp = 1; s.tleft = 0; s.dir = 1; run(s);
      // R8: error from credit 1 and from 0
      s = base(); s.rsp = 1; s.cerr = 1; run(s);
      s = base(); s.rsp = 1; s.cerr = 0; run(s);
      // R9: ACK OUT, bytes below and above max packet, offset wrap
      s = base(); s.rsp = 2; s.dir = 0; s.cerr = 1; run(s);
      s = base(); s.rsp = 2; s.dir = 0; s.bytes = 30; s.offset = 240; s.toggle = 1; run(s);
      // R10: MDATA IN with accumulator wrap
      s = base(); s.rsp = 3; s.sbytes = 30; s.rx = 5; s.cerr = 2; run(s);
      // R11: illegal ACK on IN, illegal MDATA on OUT
      s = base(); s.rsp = 2; s.dir = 1; run(s);
      s = base(); s.rsp = 3; s.dir = 0; s.tleft = 0; s.cerr = 2; run(s);
      // R12: idle cycle gives no valid
      cs_valid = 1'b0;
      @(negedge clk);
      cmp("R12", "idle valid", int'(res_valid), 0);
      for (int i = 0; i < 3000; i++) begin
         s = rnd();
         run(s);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule